// File: doc/BRIEF.md
# Fixed-Point Time Accumulator with Remainder Correction

This block keeps a running time value in fixed-point form. Each accepted tick adds a whole-unit step. The true tick period is not a whole number of fixed-point units, so the block also carries the part that the step leaves out. With the default parameters, the tick is 0.1 s and the time has 8 fractional bits. The exact increment is then 25.6 units: the step is 25 and the leftover is 6/10 of a unit. The leftover goes into a small error register. When that register reaches the modulus, the time gains one extra unit and the modulus is subtracted from the register. The error therefore stays below the modulus, and the time value never drifts away from the ideal count.

A host block drives `tick_i` once per period and reads `time_o` as the fixed-point time. The low bits of `time_o` are the fraction. `err_o` gives the current residue in units of 1/MODULUS of an LSB. `clr_i` restarts the count from zero. `rst_n` asserts at once, and its release is synchronised to the clock.

The step, remainder and modulus are parameters. The remainder must be smaller than the modulus. When the remainder is zero, the block builds without an error register.

Top module: `frac_time_accum`

## Requirements
- R1: While `rst_n` is low, and on the first clock after its release, `time_o` and `err_o` are both 0. Assertion of `rst_n` clears them without waiting for a clock edge.
- R2: On an accepted tick (`tick_i`=1, `clr_i`=0) where `err_o` + STEP_REM < MODULUS, `time_o` grows by exactly STEP_INT and `err_o` grows by STEP_REM at that clock edge.
- R3: On an accepted tick where `err_o` + STEP_REM >= MODULUS, `time_o` grows by STEP_INT + 1 in the same edge, and `err_o` becomes `err_o` + STEP_REM - MODULUS.
- R4: `err_o` is always less than MODULUS.
- R5: After N accepted ticks from zero, `time_o` = floor(N*(STEP_INT*MODULUS + STEP_REM)/MODULUS) and `err_o` = (N*STEP_REM) mod MODULUS. With the defaults this gives the sequence (25,6), (51,2), (76,8), (102,4).
- R6: With `tick_i`=0 and `clr_i`=0, both `time_o` and `err_o` keep their values.
- R7: `clr_i`=1 sets both outputs to 0 at the next clock edge, even when `tick_i` is 1 in that cycle.
- R8: `time_o` wraps modulo 2^TIME_W. The error term is unaffected by the wrap.
- R9: With STEP_REM = 0, `err_o` stays 0 and every accepted tick adds exactly STEP_INT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| clr_i | input | 1 | Synchronous restart of time and error to zero |
| tick_i | input | 1 | Advance by one tick period at this edge |
| time_o | output | TIME_W | Fixed-point time; the low 8 bits are the fraction with the default step |
| err_o | output | ERR_W | Residue in units of 1/MODULUS of an LSB (ERR_W = ceil(log2 MODULUS), min 1) |

## Verification
The bench builds three copies of the block that share one stimulus. The first uses the defaults: a 32-bit time, step 25, remainder 6 and modulus 10. It exercises the carry sequence and runs of more than a thousand ticks against the floor formula. The second narrows the time to 8 bits, so the wrap at 256 is reached after only ten ticks. The third sets the remainder to zero, which brings the variant without an error register into the same run.

// File: rtl/ftacc_pkg.sv
package ftacc_pkg;

  // Action applied to the accumulators at the next clock edge
  typedef enum logic [1:0] {
    ADV_HOLD  = 2'd0,
    ADV_STEP  = 2'd1,
    ADV_CARRY = 2'd2,
    ADV_CLEAR = 2'd3
  } adv_e;

  // Width of the residue register for a given modulus (at least one bit)
  function automatic int err_width(input int modulus);
    return (modulus <= 2) ? 1 : $clog2(modulus);
  endfunction

endpackage

// File: rtl/ftacc_rst_sync.sv
module ftacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ftacc_rem.sv
module ftacc_rem
  import ftacc_pkg::*;
#(
  parameter int MODULUS  = 10,
  parameter int STEP_REM = 6,
  parameter int ERR_W    = err_width(MODULUS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  adv_e             act_i,
  output logic [ERR_W-1:0] err_o,
  output logic             carry_o
);

  generate
    if (STEP_REM == 0) begin : g_exact
      // The step is exact: there is no residue to keep
      logic unused_ok;
      assign unused_ok = ^{clk, rst_n, act_i};
      assign err_o     = '0;
      assign carry_o   = 1'b0;
    end else begin : g_frac
      localparam int SUM_W = ERR_W + 1;
      localparam logic [SUM_W-1:0] REM_S = SUM_W'(STEP_REM);
      localparam logic [SUM_W-1:0] MOD_S = SUM_W'(MODULUS);

      logic [ERR_W-1:0] err_q;
      logic [ERR_W-1:0] err_d;
      logic [SUM_W-1:0] sum;
      logic             ovf;

      assign sum     = {1'b0, err_q} + REM_S;
      assign ovf     = (sum >= MOD_S);
      assign carry_o = ovf;

      always_comb begin
        err_d = err_q;
        unique case (act_i)
          ADV_CLEAR:           err_d = '0;
          ADV_STEP, ADV_CARRY: err_d = ovf ? ERR_W'(sum - MOD_S) : ERR_W'(sum);
          default:             err_d = err_q;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          err_q <= '0;
        end else if (act_i != ADV_HOLD) begin
          err_q <= err_d;
        end
      end

      assign err_o = err_q;
    end
  endgenerate

endmodule

// File: rtl/ftacc_time.sv
module ftacc_time
  import ftacc_pkg::*;
#(
  parameter int TIME_W   = 32,
  parameter int STEP_INT = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  adv_e              act_i,
  output logic [TIME_W-1:0] time_o
);

  localparam logic [TIME_W-1:0] STEP_T  = TIME_W'(STEP_INT);
  localparam logic [TIME_W-1:0] STEP_T1 = TIME_W'(STEP_INT + 1);

  logic [TIME_W-1:0] time_q;
  logic [TIME_W-1:0] time_d;

  always_comb begin
    time_d = time_q;
    unique case (act_i)
      ADV_CLEAR: time_d = '0;
      ADV_STEP:  time_d = time_q + STEP_T;
      ADV_CARRY: time_d = time_q + STEP_T1;
      default:   time_d = time_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (act_i != ADV_HOLD) begin
      time_q <= time_d;
    end
  end

  assign time_o = time_q;

endmodule

// File: rtl/frac_time_accum.sv
module frac_time_accum
  import ftacc_pkg::*;
#(
  parameter int TIME_W   = 32,
  parameter int STEP_INT = 25,
  parameter int STEP_REM = 6,
  parameter int MODULUS  = 10,
  localparam int ERR_W   = err_width(MODULUS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              tick_i,
  output logic [TIME_W-1:0] time_o,
  output logic [ERR_W-1:0]  err_o
);

  logic rst_q_n;
  logic carry;
  adv_e act;

  ftacc_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q_n)
  );

  // Clear wins over tick; a tick carries when the residue overflows
  always_comb begin
    if (clr_i) begin
      act = ADV_CLEAR;
    end else if (tick_i) begin
      act = carry ? ADV_CARRY : ADV_STEP;
    end else begin
      act = ADV_HOLD;
    end
  end

  ftacc_rem #(
    .MODULUS  (MODULUS),
    .STEP_REM (STEP_REM),
    .ERR_W    (ERR_W)
  ) u_rem (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .act_i   (act),
    .err_o   (err_o),
    .carry_o (carry)
  );

  ftacc_time #(
    .TIME_W   (TIME_W),
    .STEP_INT (STEP_INT)
  ) u_time (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .act_i  (act),
    .time_o (time_o)
  );

endmodule

// File: rtl/ftacc_chk.sv
module ftacc_chk #(
  parameter int TIME_W   = 32,
  parameter int STEP_INT = 25,
  parameter int STEP_REM = 6,
  parameter int MODULUS  = 10,
  parameter int ERR_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              tick_i,
  input logic [TIME_W-1:0] time_o,
  input logic [ERR_W-1:0]  err_o
);

  localparam logic [ERR_W:0]    MOD_X   = (ERR_W+1)'(MODULUS);
  localparam logic [ERR_W:0]    REM_X   = (ERR_W+1)'(STEP_REM);
  localparam logic [TIME_W-1:0] STEP_T  = TIME_W'(STEP_INT);
  localparam logic [TIME_W-1:0] STEP_T1 = TIME_W'(STEP_INT + 1);

  logic [ERR_W:0] nxt_sum;
  logic           take;

  assign nxt_sum = {1'b0, err_o} + REM_X;
  assign take    = tick_i && !clr_i;

  // R4
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, err_o} < MOD_X);

  // R2
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && (nxt_sum < MOD_X) |=>
      (time_o == $past(time_o) + STEP_T) && ({1'b0, err_o} == $past(nxt_sum)));

  // R3
  carry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && (nxt_sum >= MOD_X) |=>
      (time_o == $past(time_o) + STEP_T1) && ({1'b0, err_o} == $past(nxt_sum) - MOD_X));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !clr_i |=> $stable(time_o) && $stable(err_o));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (time_o == '0) && (err_o == '0));

endmodule

bind frac_time_accum ftacc_chk #(
  .TIME_W   (TIME_W),
  .STEP_INT (STEP_INT),
  .STEP_REM (STEP_REM),
  .MODULUS  (MODULUS),
  .ERR_W    (ERR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_q_n),
  .clr_i  (clr_i),
  .tick_i (tick_i),
  .time_o (time_o),
  .err_o  (err_o)
);

// File: tb/test_frac_time_accum.sv
`timescale 1ns/1ps
module test_frac_time_accum;

  localparam int  STEP  = 25;
  localparam int  REM   = 6;
  localparam int  MODV  = 10;
  localparam int  NVEC  = 8;
  // exact ticks-per-period numerator: STEP*MODV + REM = 256
  localparam longint SCALE = longint'(STEP * MODV + REM);

  // {ticks to apply, expected time, expected error}, cumulative from a clear
  localparam int VEC [NVEC][3] = '{
    '{1, 25, 6}, '{1, 51, 2}, '{1, 76, 8}, '{1, 102, 4},
    '{6, 256, 0}, '{7, 435, 2}, '{23, 1024, 0}, '{3, 1100, 8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] time_m;
  logic [3:0]  err_m;
  logic [7:0]  time_w;
  logic [3:0]  err_w;
  logic [31:0] time_z;
  logic [3:0]  err_z;

  int     checks = 0;
  int     errors = 0;
  longint ntot = 0;

  always #10 clk = ~clk;

  frac_time_accum i_frac_time_accum (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick),
    .time_o(time_m), .err_o(err_m)
  );

  frac_time_accum #(.TIME_W(8)) i_frac_time_accum_w (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick),
    .time_o(time_w), .err_o(err_w)
  );

  frac_time_accum #(.STEP_REM(0)) i_frac_time_accum_z (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick),
    .time_o(time_z), .err_o(err_z)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // Expected values of all three copies after ntot accepted ticks
  task automatic chk_all(input string req);
    chk({req, " main time"}, longint'(time_m), (ntot * SCALE) / MODV);
    chk({req, " main err"},  longint'(err_m),  (ntot * REM) % MODV);
    // R8: narrow copy wraps modulo 256
    chk({req, " R8 wrap time"}, longint'(time_w), ((ntot * SCALE) / MODV) % 256);
    chk({req, " R8 wrap err"},  longint'(err_w),  (ntot * REM) % MODV);
    // R9: exact-step copy
    chk({req, " R9 exact time"}, longint'(time_z), ntot * STEP);
    chk({req, " R9 exact err"},  longint'(err_z),  0);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    ntot += n;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    ntot = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #3ms;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    longint t0;
    int     bad;
    // R1: reset state while held
    #5;
    chk("R1 reset time", longint'(time_m), 0);
    chk("R1 reset err",  longint'(err_m),  0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1 after release");

    // R5: vector table walked in one loop
    for (int i = 0; i < NVEC; i++) begin
      run_ticks(VEC[i][0]);
      chk("R5 vec time", longint'(time_m), longint'(VEC[i][2-1]));
      chk("R5 vec err",  longint'(err_m),  longint'(VEC[i][2]));
      chk_all("R5 vec");
    end

    // R6: idle cycles leave everything untouched
    t0 = longint'(time_m);
    repeat (6) @(negedge clk);
    chk("R6 idle time", longint'(time_m), t0);
    chk_all("R6 idle");

    // R7: clear takes priority over a simultaneous tick
    @(negedge clk);
    clr  = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    clr  = 1'b0;
    tick = 1'b0;
    ntot = 0;
    chk("R7 clear time", longint'(time_m), 0);
    chk("R7 clear err",  longint'(err_m),  0);

    // R2: tick from err 0 adds exactly the step
    run_ticks(1);
    chk("R2 plain step", longint'(time_m), 25);
    // R3: err 6 + 6 overflows, step plus one
    t0 = longint'(time_m);
    run_ticks(1);
    chk("R3 carry delta", longint'(time_m) - t0, 26);
    chk("R3 carry err", longint'(err_m), 2);
    // R2: err 2 + 6 stays below modulus
    t0 = longint'(time_m);
    run_ticks(1);
    chk("R2 plain delta", longint'(time_m) - t0, 25);

    // R4: residue bound over a continuous run
    bad = 0;
    @(negedge clk);
    tick = 1'b1;
    for (int k = 0; k < 37; k++) begin
      @(negedge clk);
      if (err_m >= 4'd10) bad++;
    end
    tick = 1'b0;
    ntot += 37;
    chk("R4 err bound violations", longint'(bad), 0);
    chk_all("R4 run");

    // R5: long run from a clear
    do_clear();
    chk_all("R7 do_clear");
    run_ticks(1003);
    chk_all("R5 long");
    chk("R5 long time", longint'(time_m), 25676);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    #3;
    rst_n = 1'b0;
    #2;
    chk("R1 async time", longint'(time_m), 0);
    chk("R1 async err",  longint'(err_m),  0);
    @(negedge clk);
    rst_n = 1'b1;
    ntot = 0;
    repeat (4) @(negedge clk);
    run_ticks(2);
    chk_all("R1 after second release");

    finish_run();
  end

endmodule